// File: doc/BRIEF.md
# Pin-Level Scan Test Sequencer

This block is a board-level test controller that checks whether a chip's pins are soldered correctly and are free of opens and shorts. When the active-low test input is driven low, the block holds the rest of the chip in reset. It then uses the bus address-enable strobe as its step input, and does so only if that strobe was already low when test mode began. After an initial all-tri-stated state, each falling edge of the strobe advances the block by one position. There are two phases.

The drive phase has 34 positions. At each position one pin is pulled low and every other output and bidirectional pin is driven high. The sample phase follows. It visits 33 input pins and 17 bidirectional pins one at a time, in the opposite rotational direction, and copies the level of the selected pin onto one serial observation output. The strobe is oversampled by the system clock, so all sequencing stays in one clock domain. Releasing the test input returns the block to idle at once, without waiting for a clock edge.

Top module: `scan_pin_sequencer`

## Requirements
- R1: While `test_n` is high, `phase` reads 0 (idle), `chip_hold` is 0, `obs_out` is 0, and every output enable is 0.
- R2: While `test_n` is low, `chip_hold` is 1, whatever the scan state.
- R3: Stepping is qualified at entry. If the synchronized strobe is high once the test-low level has been synchronized, `phase` becomes 1 (blocked) and stays there until `test_n` rises. In that state strobe edges are ignored and all output enables stay 0.
- R4: If the strobe is low at entry, `phase` becomes 2 (tri-state). All output enables stay 0 until the first strobe falling edge. They are also 0 in every phase other than drive.
- R5: Each strobe falling edge advances `pos` by one, or moves to the next phase. With no falling edge, `phase` and `pos` stay unchanged. The strobe must hold each level for at least SYNC_STAGES+1 clocks.
- R6: In drive (`phase`=3), all output and bidirectional enables are 1 and exactly one value is 0. Position p in 0..16 pulls `out_val[p]` low. Position p in 17..33 pulls `bidi_val[p-17]` low. All other values are 1.
- R7: The falling edge taken at drive position 33 enters sample (`phase`=4) at position 0, with all enables 0.
- R8: In sample, form s = {bidi_in, in_pins}, a 50-bit vector whose bit 49 is `bidi_in[16]`. Position k shows s[49-k] on `obs_out`, one clock after the pin level settles.
- R9: The falling edge taken at sample position 49 enters done (`phase`=5). In done, `obs_out` is 0, all enables are 0, and later strobe edges are ignored.
- R10: A rise of `test_n` in any state sets `phase` to 0 and all enables to 0 at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the strobe |
| rst_n | input | 1 | Active-low power-on reset |
| test_n | input | 1 | Active-low scan test enable |
| strobe_in | input | 1 | Address-enable strobe; its falling edge steps the sequence |
| in_pins | input | N_IN | Levels of the input-only pins |
| bidi_in | input | N_BIDI | Levels sensed on the bidirectional pins |
| out_val | output | N_OUT | Drive values for the output-only pins |
| out_oe | output | N_OUT | Output enables for the output-only pins |
| bidi_val | output | N_BIDI | Drive values for the bidirectional pins |
| bidi_oe | output | N_BIDI | Output enables for the bidirectional pins |
| chip_hold | output | 1 | Holds the rest of the chip in internal reset |
| obs_out | output | 1 | Serial observation output |
| phase | output | 3 | Current phase code |
| pos | output | POS_W | Position index within the phase |

## Verification
The bench builds the block with its default parameters: 17 output pins, 17 bidirectional pins, 33 input pins and a two-stage synchronizer. These values cover the full 34-step walking zero, including the hand-over from the output group to the bidirectional group at position 17. They also cover all 50 sample positions. Each sample position is checked with a one-hot pattern and its complement, so a wrong index cannot go unnoticed. The short synchronizer keeps every step to a few clocks, which leaves room to test the blocked entry and an asynchronous abort in the middle of the drive phase.

// File: rtl/scan_pkg.sv
package scan_pkg;
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_BLOCKED = 3'd1,
        PH_HIZ     = 3'd2,
        PH_DRIVE   = 3'd3,
        PH_SAMPLE  = 3'd4,
        PH_DONE    = 3'd5
    } phase_e;
endpackage

// File: rtl/scan_sync.sv
// Synchronizes the strobe into the clock domain and flags its falling edge.
module scan_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q,
    output logic fell
);
    localparam int CHAIN = STAGES + 1;

    typedef struct packed {
        logic [CHAIN-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[CHAIN-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= '{chain: '1};
        else         s_q <= s_d;
    end

    assign q    = s_q.chain[STAGES-1];
    assign fell = s_q.chain[STAGES] & ~s_q.chain[STAGES-1];
endmodule

// File: rtl/scan_seq_fsm.sv
// Phase and position sequencer; an async reset clears it whenever test mode is left.
module scan_seq_fsm
    import scan_pkg::*;
#(
    parameter int N_DRIVE     = 34,
    parameter int N_SAMPLE    = 50,
    parameter int POS_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             strobe_lvl,
    input  logic             step,
    output phase_e           phase,
    output logic [POS_W-1:0] pos
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] arm;
        phase_e                 phase;
        logic [POS_W-1:0]       pos;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.arm = {f_q.arm[SYNC_STAGES-2:0], 1'b1};
        unique case (f_q.phase)
            PH_IDLE: begin
                if (f_q.arm[SYNC_STAGES-1]) begin
                    f_d.phase = strobe_lvl ? PH_BLOCKED : PH_HIZ;
                    f_d.pos   = '0;
                end
            end
            PH_BLOCKED: f_d.phase = PH_BLOCKED;
            PH_HIZ: begin
                if (step) begin
                    f_d.phase = PH_DRIVE;
                    f_d.pos   = '0;
                end
            end
            PH_DRIVE: begin
                if (step) begin
                    if (f_q.pos == POS_W'(N_DRIVE - 1)) begin
                        f_d.phase = PH_SAMPLE;
                        f_d.pos   = '0;
                    end else begin
                        f_d.pos = f_q.pos + POS_W'(1);
                    end
                end
            end
            PH_SAMPLE: begin
                if (step) begin
                    if (f_q.pos == POS_W'(N_SAMPLE - 1)) begin
                        f_d.phase = PH_DONE;
                        f_d.pos   = '0;
                    end else begin
                        f_d.pos = f_q.pos + POS_W'(1);
                    end
                end
            end
            PH_DONE: f_d.phase = PH_DONE;
            default: begin
                f_d.phase = PH_IDLE;
                f_d.pos   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) f_q <= '{arm: '0, phase: PH_IDLE, pos: '0};
        else         f_q <= f_d;
    end

    assign phase = f_q.phase;
    assign pos   = f_q.pos;
endmodule

// File: rtl/scan_drive_decode.sv
// Walking-zero decode of the drive phase onto output and bidirectional pins.
module scan_drive_decode
    import scan_pkg::*;
#(
    parameter int N_OUT  = 17,
    parameter int N_BIDI = 17,
    parameter int POS_W  = 6
) (
    input  phase_e            phase,
    input  logic [POS_W-1:0]  pos,
    output logic [N_OUT-1:0]  out_val,
    output logic [N_OUT-1:0]  out_oe,
    output logic [N_BIDI-1:0] bidi_val,
    output logic [N_BIDI-1:0] bidi_oe
);
    logic driving;
    assign driving = (phase == PH_DRIVE);

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        assign out_oe[i]  = driving;
        assign out_val[i] = ~(driving && (pos == POS_W'(i)));
    end

    for (genvar j = 0; j < N_BIDI; j++) begin : g_bidi
        assign bidi_oe[j]  = driving;
        assign bidi_val[j] = ~(driving && (pos == POS_W'(N_OUT + j)));
    end
endmodule

// File: rtl/scan_obs_select.sv
// Picks the sampled pin for the current position and registers it onto the serial output.
module scan_obs_select
    import scan_pkg::*;
#(
    parameter int N_SAMPLE = 50,
    parameter int POS_W    = 6
) (
    input  logic                clk,
    input  logic                arst_n,
    input  phase_e              phase,
    input  logic [POS_W-1:0]    pos,
    input  logic [N_SAMPLE-1:0] sample_vec,
    output logic                obs
);
    typedef struct packed {
        logic obs;
    } obs_t;

    obs_t o_d, o_q;

    always_comb begin
        o_d.obs = 1'b0;
        if (phase == PH_SAMPLE) begin
            for (int i = 0; i < N_SAMPLE; i++) begin
                if (pos == POS_W'(N_SAMPLE - 1 - i)) o_d.obs = sample_vec[i];
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) o_q <= '{obs: 1'b0};
        else         o_q <= o_d;
    end

    assign obs = o_q.obs;
endmodule

// File: rtl/scan_pin_sequencer.sv
module scan_pin_sequencer
    import scan_pkg::*;
#(
    parameter int N_OUT       = 17,
    parameter int N_BIDI      = 17,
    parameter int N_IN        = 33,
    parameter int SYNC_STAGES = 2,
    parameter int POS_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_n,
    input  logic              strobe_in,
    input  logic [N_IN-1:0]   in_pins,
    input  logic [N_BIDI-1:0] bidi_in,
    output logic [N_OUT-1:0]  out_val,
    output logic [N_OUT-1:0]  out_oe,
    output logic [N_BIDI-1:0] bidi_val,
    output logic [N_BIDI-1:0] bidi_oe,
    output logic              chip_hold,
    output logic              obs_out,
    output logic [2:0]        phase,
    output logic [POS_W-1:0]  pos
);
    localparam int N_DRIVE  = N_OUT + N_BIDI;
    localparam int N_SAMPLE = N_IN + N_BIDI;

    logic   scan_rst_n;
    logic   strobe_lvl;
    logic   step;
    phase_e phase_w;

    assign scan_rst_n = rst_n & ~test_n;
    assign chip_hold  = ~test_n;

    scan_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (rst_n),
        .d      (strobe_in),
        .q      (strobe_lvl),
        .fell   (step)
    );

    scan_seq_fsm #(
        .N_DRIVE     (N_DRIVE),
        .N_SAMPLE    (N_SAMPLE),
        .POS_W       (POS_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_fsm (
        .clk        (clk),
        .arst_n     (scan_rst_n),
        .strobe_lvl (strobe_lvl),
        .step       (step),
        .phase      (phase_w),
        .pos        (pos)
    );

    scan_drive_decode #(
        .N_OUT  (N_OUT),
        .N_BIDI (N_BIDI),
        .POS_W  (POS_W)
    ) u_drive (
        .phase    (phase_w),
        .pos      (pos),
        .out_val  (out_val),
        .out_oe   (out_oe),
        .bidi_val (bidi_val),
        .bidi_oe  (bidi_oe)
    );

    scan_obs_select #(
        .N_SAMPLE (N_SAMPLE),
        .POS_W    (POS_W)
    ) u_obs (
        .clk        (clk),
        .arst_n     (scan_rst_n),
        .phase      (phase_w),
        .pos        (pos),
        .sample_vec ({bidi_in, in_pins}),
        .obs        (obs_out)
    );

    assign phase = phase_w;
endmodule

// File: rtl/scan_pin_sequencer_chk.sv
module scan_pin_sequencer_chk
    import scan_pkg::*;
#(
    parameter int N_OUT    = 17,
    parameter int N_BIDI   = 17,
    parameter int N_SAMPLE = 50,
    parameter int POS_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_n,
    input logic              step,
    input logic [2:0]        phase,
    input logic [POS_W-1:0]  pos,
    input logic [N_OUT-1:0]  out_val,
    input logic [N_OUT-1:0]  out_oe,
    input logic [N_BIDI-1:0] bidi_val,
    input logic [N_BIDI-1:0] bidi_oe,
    input logic              obs_out
);
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        test_n |-> (phase == PH_IDLE && out_oe == '0 && bidi_oe == '0));

    assert_blocked_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n || test_n)
        (phase == PH_BLOCKED) |=> (phase == PH_BLOCKED));

    assert_oe_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n || test_n)
        (phase != PH_DRIVE) |-> (out_oe == '0 && bidi_oe == '0));

    assert_hold_without_step_R5: assert property (@(posedge clk) disable iff (!rst_n || test_n)
        ((phase == PH_DRIVE || phase == PH_SAMPLE) && !step) |=> ($stable(pos) && $stable(phase)));

    assert_single_zero_R6: assert property (@(posedge clk) disable iff (!rst_n || test_n)
        (phase == PH_DRIVE) |-> ($countones(~{bidi_val, out_val}) == 1 && (&{bidi_oe, out_oe})));

    assert_sample_range_R8: assert property (@(posedge clk) disable iff (!rst_n || test_n)
        (phase == PH_SAMPLE) |-> (pos < POS_W'(N_SAMPLE)));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n || test_n)
        (phase == PH_DONE) |=> (phase == PH_DONE && !obs_out));
endmodule

bind scan_pin_sequencer scan_pin_sequencer_chk #(
    .N_OUT    (N_OUT),
    .N_BIDI   (N_BIDI),
    .N_SAMPLE (N_IN + N_BIDI),
    .POS_W    (POS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_n   (test_n),
    .step     (step),
    .phase    (phase),
    .pos      (pos),
    .out_val  (out_val),
    .out_oe   (out_oe),
    .bidi_val (bidi_val),
    .bidi_oe  (bidi_oe),
    .obs_out  (obs_out)
);

// File: tb/tb_scan_pin_sequencer.sv
`timescale 1ns/1ps
module tb_scan_pin_sequencer;
    localparam int NO = 17, NB = 17, NI = 33, PW = 6;
    localparam int ND = NO + NB, NS = NI + NB;

    logic clk = 1'b0, rst_n = 1'b0, test_n = 1'b1, strobe_in = 1'b0;
    logic [NI-1:0] in_pins = '0;
    logic [NB-1:0] bidi_in = '0;
    logic [NO-1:0] out_val, out_oe;
    logic [NB-1:0] bidi_val, bidi_oe;
    logic chip_hold, obs_out;
    logic [2:0] phase;
    logic [PW-1:0] pos;
    int n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    scan_pin_sequencer dut (
        .clk(clk), .rst_n(rst_n), .test_n(test_n), .strobe_in(strobe_in),
        .in_pins(in_pins), .bidi_in(bidi_in), .out_val(out_val), .out_oe(out_oe),
        .bidi_val(bidi_val), .bidi_oe(bidi_oe), .chip_hold(chip_hold),
        .obs_out(obs_out), .phase(phase), .pos(pos)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        strobe_in = 1'b1; wait_clk(4);
        strobe_in = 1'b0; wait_clk(4);
    endtask

    task automatic enter(input logic lvl);
        strobe_in = lvl; wait_clk(4);
        test_n = 1'b0;   wait_clk(6);
    endtask

    task automatic leave();
        test_n = 1'b1; strobe_in = 1'b0; wait_clk(4);
    endtask

    task automatic t_reset();
        chk("R1 phase", 64'(phase), 64'd0);
        chk("R1 oe", 64'({bidi_oe, out_oe}), 64'd0);
        chk("R1 hold", 64'(chip_hold), 64'd0);
        chk("R1 obs", 64'(obs_out), 64'd0);
    endtask

    task automatic t_blocked();
        enter(1'b1);
        chk("R3 blocked phase", 64'(phase), 64'd1);
        chk("R2 hold in blocked", 64'(chip_hold), 64'd1);
        strobe_in = 1'b0; wait_clk(4);
        pulse();
        chk("R3 falls ignored", 64'(phase), 64'd1);
        chk("R3 oe off", 64'({bidi_oe, out_oe}), 64'd0);
        leave();
        chk("R1 back idle", 64'(phase), 64'd0);
    endtask

    task automatic t_full_scan();
        logic [ND-1:0] exp_w;
        logic [NS-1:0] s;
        enter(1'b0);
        chk("R4 hiz phase", 64'(phase), 64'd2);
        chk("R4 hiz oe", 64'({bidi_oe, out_oe}), 64'd0);
        chk("R2 hold", 64'(chip_hold), 64'd1);
        for (int p = 0; p < ND; p++) begin
            if (p == 5) begin
                strobe_in = 1'b1; wait_clk(20);
                chk("R5 no step while high", 64'(pos), 64'd4);
                strobe_in = 1'b0; wait_clk(4);
            end else begin
                pulse();
            end
            exp_w = ~(ND'(1) << p);
            chk("R6 drive phase", 64'(phase), 64'd3);
            chk("R5 drive pos", 64'(pos), 64'(p));
            chk("R6 walking zero", 64'({bidi_val, out_val}), 64'(exp_w));
            chk("R6 all oe", 64'({bidi_oe, out_oe}), 64'({ND{1'b1}}));
        end
        pulse();
        chk("R7 sample phase", 64'(phase), 64'd4);
        chk("R7 sample pos", 64'(pos), 64'd0);
        chk("R7 oe off", 64'({bidi_oe, out_oe}), 64'd0);
        for (int k = 0; k < NS; k++) begin
            if (k > 0) pulse();
            chk("R5 sample pos", 64'(pos), 64'(k));
            s = NS'(1) << (NS - 1 - k);
            {bidi_in, in_pins} = s; wait_clk(3);
            chk("R8 obs one-hot", 64'(obs_out), 64'd1);
            {bidi_in, in_pins} = ~s; wait_clk(3);
            chk("R8 obs inverted", 64'(obs_out), 64'd0);
        end
        {bidi_in, in_pins} = '1;
        pulse();
        chk("R9 done phase", 64'(phase), 64'd5);
        chk("R9 obs low", 64'(obs_out), 64'd0);
        chk("R9 oe off", 64'({bidi_oe, out_oe}), 64'd0);
        pulse();
        chk("R9 stays done", 64'(phase), 64'd5);
        leave();
        chk("R1 idle after done", 64'(phase), 64'd0);
        chk("R1 hold released", 64'(chip_hold), 64'd0);
    endtask

    task automatic t_abort();
        enter(1'b0);
        pulse(); pulse(); pulse();
        chk("R6 pos before abort", 64'(pos), 64'd2);
        @(negedge clk);
        #1 test_n = 1'b1;
        #2;
        chk("R10 async idle", 64'(phase), 64'd0);
        chk("R10 async oe off", 64'({bidi_oe, out_oe}), 64'd0);
        strobe_in = 1'b0; wait_clk(4);
    endtask

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_blocked();
        t_full_scan();
        t_abort();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule